// File: doc/BRIEF.md
# Byte-Lane Data Mask Pipeline

This block sits on the 32-bit data path of a synchronous memory interface and applies a 4-bit byte mask with two different timings. For a write the mask acts at once: each mask bit that is low at a rising edge turns on the write enable of its byte lane for the word presented on that same edge. For a read the mask is delayed by a fixed two clocks and then switches off the output enables of the matching byte lanes of the read data. The masked bytes are not replaced with zeros; their drivers are simply turned off.

The block also holds the read-data latency pipeline. A read issued at an edge captures the word from the core, and that word comes out for sampling two or three edges later, depending on a latency select. The two-clock mask timing does not depend on this select. The mask is also not qualified by any command or chip select. The clock enable input freezes both delay lines and blocks new reads and write enables while it is low.

Top module: `lane_mask_pipe`

## Requirements
- R1: Mask bit i covers byte lane i, which is data bits 8*i+7 down to 8*i. Write enable bit i and output enable bit i belong to that same lane.
- R2: While the clock enable is high and a write is issued, `wr_be` equals the inverse of `dqm` on the same cycle. When no write is issued, `wr_be` is all zero.
- R3: With `lat_sel` = 0, a word captured from `rd_core_data` at the rising edge where `rd_issue` and `cke` are high appears on `rd_data`, with its lanes enabled, for sampling at the second following enabled edge.
- R4: With `lat_sel` = 1, the captured word appears for sampling at the third following enabled edge.
- R5: A `dqm` bit that is high at an enabled edge k drives `rd_oe` of that lane low for the data sampled at enabled edge k+2. This holds under both latency settings.
- R6: The read mask is taken at every enabled edge whatever command is issued on it, including edges with no read and edges with a write.
- R7: While `cke` is low, the mask delay and the read-data pipeline hold their contents. `rd_oe` and `rd_data` stay unchanged, `rd_issue` is ignored, and `wr_be` is all zero.
- R8: During reset and right after it, `rd_oe` is all zero, and a read request seen while reset is asserted produces no data.
- R9: A masked read lane still carries the read byte on `rd_data`; only its output enable goes low.
- R10: When no read was issued at the edge that feeds the current output slot, `rd_oe` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable; low freezes all pipelines |
| dqm | input | 4 | Per-byte mask, bit i for lane i |
| rd_issue | input | 1 | A read is issued on this edge |
| wr_issue | input | 1 | A write word is presented on this edge |
| lat_sel | input | 1 | Read latency: 0 selects 2 clocks, 1 selects 3 clocks |
| wr_data | input | 32 | Write word from the bus |
| rd_core_data | input | 32 | Word read from the core on the read edge |
| wr_be | output | 4 | Per-byte write enables for the current word |
| wr_word | output | 32 | Write word passed on to the core |
| rd_data | output | 32 | Read word delayed by the selected latency |
| rd_oe | output | 4 | Per-byte output enables for `rd_data` |

## Verification
The latency assertions assume that `lat_sel` is held steady while a read is still in flight. They relate the mask of edge k to the output enables two edges later only when `cke` stayed high through the whole window. The stimulus meets the first assumption by changing `lat_sel` only after at least four enabled edges with no read. Random clock-enable gaps, mixed reads and writes, and random masks then drive all the windows the assertions watch. Latency changes take place throughout the run.

// File: rtl/lmp_pkg.sv
package lmp_pkg;
    parameter int DATA_W   = 32;
    parameter int LANE_W   = 8;
    parameter int LANES    = DATA_W / LANE_W;
    parameter int MASK_DLY = 2;
    parameter int LAT_MIN  = 2;
    parameter int LAT_MAX  = 3;

    typedef logic [LANES-1:0]  lane_vec_t;
    typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/lmp_wr_gate.sv
module lmp_wr_gate #(
    parameter int DATA_W = lmp_pkg::DATA_W,
    parameter int LANE_W = lmp_pkg::LANE_W,
    parameter int LANES  = DATA_W / LANE_W
) (
    input  logic              cke,
    input  logic              wr_issue,
    input  logic [LANES-1:0]  mask_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [LANES-1:0]  be_o,
    output logic [DATA_W-1:0] data_o
);
    logic take_write;
    assign take_write = cke & wr_issue;

    // Zero-latency mask: each lane enable depends only on this edge's inputs.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign be_o[g] = take_write & ~mask_i[g];
        assign data_o[g*LANE_W +: LANE_W] = data_i[g*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/lmp_mask_line.sv
module lmp_mask_line #(
    parameter int LANES = lmp_pkg::LANES,
    parameter int DLY   = lmp_pkg::MASK_DLY
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke,
    input  logic [LANES-1:0] mask_i,
    output logic [LANES-1:0] mask_o
);
    typedef struct packed {
        logic [DLY-1:0][LANES-1:0] stg;
    } line_state_t;

    line_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cke) begin
            st_d.stg[0] = mask_i;
            for (int i = 1; i < DLY; i++) begin
                st_d.stg[i] = st_q.stg[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_o = st_q.stg[DLY-1];
endmodule

// File: rtl/lmp_rd_lat.sv
module lmp_rd_lat #(
    parameter int W       = lmp_pkg::DATA_W,
    parameter int LAT_MIN = lmp_pkg::LAT_MIN,
    parameter int LAT_MAX = lmp_pkg::LAT_MAX,
    parameter int SEL_W   = (LAT_MAX > LAT_MIN) ? $clog2(LAT_MAX - LAT_MIN + 1) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke,
    input  logic             issue_i,
    input  logic [W-1:0]     data_i,
    input  logic [SEL_W-1:0] lat_sel,
    output logic             vld_o,
    output logic [W-1:0]     data_o
);
    localparam int DEPTH = LAT_MAX;

    typedef struct packed {
        logic [DEPTH-1:0]        vld;
        logic [DEPTH-1:0][W-1:0] dat;
    } pipe_state_t;

    pipe_state_t st_d, st_q;
    int unsigned tap;

    always_comb begin
        st_d = st_q;
        if (cke) begin
            st_d.vld[0] = issue_i;
            st_d.dat[0] = data_i;
            for (int i = 1; i < DEPTH; i++) begin
                st_d.vld[i] = st_q.vld[i-1];
                st_d.dat[i] = st_q.dat[i-1];
            end
        end
    end

    always_comb begin
        tap = unsigned'(LAT_MIN - 1) + 32'(lat_sel);
        if (tap > unsigned'(DEPTH - 1)) begin
            tap = unsigned'(DEPTH - 1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vld_o  = st_q.vld[tap];
    assign data_o = st_q.dat[tap];
endmodule

// File: rtl/lane_mask_pipe.sv
module lane_mask_pipe #(
    parameter int DATA_W   = lmp_pkg::DATA_W,
    parameter int LANE_W   = lmp_pkg::LANE_W,
    parameter int MASK_DLY = lmp_pkg::MASK_DLY,
    parameter int LAT_MIN  = lmp_pkg::LAT_MIN,
    parameter int LAT_MAX  = lmp_pkg::LAT_MAX,
    parameter int LANES    = DATA_W / LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  logic [LANES-1:0]  dqm,
    input  logic              rd_issue,
    input  logic              wr_issue,
    input  logic              lat_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] rd_core_data,
    output logic [LANES-1:0]  wr_be,
    output logic [DATA_W-1:0] wr_word,
    output logic [DATA_W-1:0] rd_data,
    output logic [LANES-1:0]  rd_oe
);
    logic [LANES-1:0] rd_mask_late;
    logic             rd_slot_vld;

    lmp_wr_gate #(
        .DATA_W (DATA_W),
        .LANE_W (LANE_W),
        .LANES  (LANES)
    ) u_wr_gate (
        .cke      (cke),
        .wr_issue (wr_issue),
        .mask_i   (dqm),
        .data_i   (wr_data),
        .be_o     (wr_be),
        .data_o   (wr_word)
    );

    lmp_mask_line #(
        .LANES (LANES),
        .DLY   (MASK_DLY)
    ) u_mask_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .cke    (cke),
        .mask_i (dqm),
        .mask_o (rd_mask_late)
    );

    lmp_rd_lat #(
        .W       (DATA_W),
        .LAT_MIN (LAT_MIN),
        .LAT_MAX (LAT_MAX),
        .SEL_W   (1)
    ) u_rd_lat (
        .clk     (clk),
        .rst_n   (rst_n),
        .cke     (cke),
        .issue_i (rd_issue),
        .data_i  (rd_core_data),
        .lat_sel (lat_sel),
        .vld_o   (rd_slot_vld),
        .data_o  (rd_data)
    );

    // A lane drives only when a word occupies the output slot and its delayed mask is clear.
    for (genvar g = 0; g < LANES; g++) begin : g_oe
        assign rd_oe[g] = rd_slot_vld & ~rd_mask_late[g];
    end
endmodule

// File: rtl/lane_mask_pipe_chk.sv
module lane_mask_pipe_chk #(
    parameter int DATA_W = 32,
    parameter int LANES  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke,
    input logic [LANES-1:0]  dqm,
    input logic              rd_issue,
    input logic              wr_issue,
    input logic              lat_sel,
    input logic [LANES-1:0]  wr_be,
    input logic [DATA_W-1:0] rd_data,
    input logic [LANES-1:0]  rd_oe
);
    assert_wr_lane_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_be & dqm) == '0);

    assert_wr_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_issue |-> wr_be == '0);

    assert_lat2_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && rd_issue && !lat_sel) ##1 cke |=> rd_oe == ~$past(dqm, 2));

    assert_lat3_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && rd_issue && lat_sel) ##1 cke ##1 cke |=> rd_oe == ~$past(dqm, 2));

    assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |=> $stable(rd_oe) && $stable(rd_data));

    assert_no_we_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> wr_be == '0);

    assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && !rd_issue && !lat_sel) ##1 cke |=> rd_oe == '0);
endmodule

bind lane_mask_pipe lane_mask_pipe_chk #(
    .DATA_W (DATA_W),
    .LANES  (LANES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cke      (cke),
    .dqm      (dqm),
    .rd_issue (rd_issue),
    .wr_issue (wr_issue),
    .lat_sel  (lat_sel),
    .wr_be    (wr_be),
    .rd_data  (rd_data),
    .rd_oe    (rd_oe)
);

// File: tb/lane_mask_pipe_tb.sv
module lane_mask_pipe_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b0;
    logic [3:0]  dqm = '0;
    logic        rd_issue = 1'b0;
    logic        wr_issue = 1'b0;
    logic        lat_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_core_data = '0;
    logic [3:0]  wr_be;
    logic [31:0] wr_word;
    logic [31:0] rd_data;
    logic [3:0]  rd_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Bench reference state: mask history and read slots, shifted on enabled edges.
    logic [3:0]  m_mask [2];
    logic        m_vld  [3];
    logic [31:0] m_dat  [3];

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_mask_pipe u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cke          (cke),
        .dqm          (dqm),
        .rd_issue     (rd_issue),
        .wr_issue     (wr_issue),
        .lat_sel      (lat_sel),
        .wr_data      (wr_data),
        .rd_core_data (rd_core_data),
        .wr_be        (wr_be),
        .wr_word      (wr_word),
        .rd_data      (rd_data),
        .rd_oe        (rd_oe)
    );

    function automatic logic [3:0] want_be(input logic c, input logic w, input logic [3:0] m);
        return (c && w) ? ~m : 4'b0000;
    endfunction

    function automatic int slot();
        return lat_sel ? 2 : 1;
    endfunction

    function automatic logic [3:0] want_oe();
        return m_vld[slot()] ? ~m_mask[1] : 4'b0000;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 2; i++) m_mask[i] = '0;
        for (int i = 0; i < 3; i++) begin
            m_vld[i] = 1'b0;
            m_dat[i] = '0;
        end
    endtask

    task automatic step(input logic c, input logic [3:0] m, input logic r, input logic w);
        string tag;
        @(negedge clk);
        if (rst_n) begin
            if (!m_vld[slot()]) tag = "R10";
            else if (m_mask[1] != 4'b0000) tag = "R5";
            else tag = lat_sel ? "R4" : "R3";
            check(tag, 32'(rd_oe), 32'(want_oe()));
            if (m_vld[slot()]) begin
                if (m_mask[1] != 4'b0000) tag = "R9";
                else tag = lat_sel ? "R4" : "R3";
                check(tag, rd_data, m_dat[slot()]);
            end
        end
        cke = c; dqm = m; rd_issue = r; wr_issue = w;
        wr_data = $urandom; rd_core_data = $urandom;
        #1;
        tag = !c ? "R7" : "R2";
        check(tag, 32'(wr_be), 32'(want_be(c, w, m)));
        check("R2", wr_word, wr_data);
        @(posedge clk);
        if (rst_n && c) begin
            m_mask[1] = m_mask[0];
            m_mask[0] = m;
            m_vld[2] = m_vld[1]; m_dat[2] = m_dat[1];
            m_vld[1] = m_vld[0]; m_dat[1] = m_dat[0];
            m_vld[0] = r;        m_dat[0] = rd_core_data;
        end
    endtask

    task automatic settle();
        #2;
    endtask

    task automatic flush_idle();
        for (int i = 0; i < 4; i++) step(1'b1, 4'($urandom), 1'b0, 1'($urandom));
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [3:0]  held_oe;
        logic [31:0] held_data;
        void'($urandom(32'h5EED_0A17));
        model_reset();

        // R8: reads requested during reset leave nothing behind.
        cke = 1'b1; rd_issue = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8", 32'(rd_oe), 32'h0);
        rd_issue = 1'b0;
        rst_n = 1'b1;
        step(1'b1, 4'h0, 1'b0, 1'b0);
        step(1'b1, 4'h0, 1'b0, 1'b0);
        settle();
        check("R8", 32'(rd_oe), 32'h0);

        // R1: one mask bit at a time clears exactly its own lane enable.
        for (int i = 0; i < 4; i++) begin
            step(1'b1, 4'(1 << i), 1'b0, 1'b1);
            settle();
            check("R1", 32'(wr_be), 32'(4'hF & ~(4'(1 << i))));
        end
        flush_idle();

        // R3: latency two, unmasked.
        lat_sel = 1'b0;
        step(1'b1, 4'h0, 1'b1, 1'b0);
        step(1'b1, 4'h0, 1'b0, 1'b0);
        settle();
        check("R3", 32'(rd_oe), 32'hF);

        // R5 and R9: mask on the read edge, latency two.
        step(1'b1, 4'b0110, 1'b1, 1'b0);
        step(1'b1, 4'h0, 1'b0, 1'b0);
        settle();
        check("R5", 32'(rd_oe), 32'b1001);
        check("R9", rd_data, m_dat[1]);
        flush_idle();

        // R4 and R6: latency three, mask raised on an edge with no read.
        lat_sel = 1'b1;
        step(1'b1, 4'h0, 1'b1, 1'b0);
        step(1'b1, 4'b0101, 1'b0, 1'b0);
        step(1'b1, 4'h0, 1'b0, 1'b0);
        settle();
        check("R6", 32'(rd_oe), 32'b1010);
        check("R4", rd_data, m_dat[2]);
        flush_idle();

        // R7: clock enable low freezes outputs and blocks writes and reads.
        lat_sel = 1'b0;
        step(1'b1, 4'b1000, 1'b1, 1'b0);
        step(1'b1, 4'h0, 1'b0, 1'b0);
        settle();
        held_oe = rd_oe;
        held_data = rd_data;
        for (int i = 0; i < 3; i++) begin
            step(1'b0, 4'hF, 1'b1, 1'b1);
            settle();
            check("R7", 32'(rd_oe), 32'(held_oe));
            check("R7", rd_data, held_data);
            check("R7", 32'(wr_be), 32'h0);
        end
        step(1'b1, 4'h0, 1'b0, 1'b0);
        flush_idle();

        // Random traffic with latency changes only after an idle flush.
        for (int blk = 0; blk < 12; blk++) begin
            flush_idle();
            lat_sel = 1'($urandom);
            for (int i = 0; i < 250; i++) begin
                logic c;
                logic r;
                logic w;
                int   pick;
                c = ($urandom % 100) < 85;
                pick = $urandom % 10;
                r = pick < 4;
                w = (pick >= 4) && (pick < 7);
                step(c, 4'($urandom), r, w);
            end
        end
        flush_idle();

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule